// File: doc/BRIEF.md
# Shift Micro-Operation Unit

This block holds one data word in a register and changes it by a single shift micro-operation per clock cycle. A 2-bit opcode chooses the shift. There are two arithmetic shifts (right and left), one logical left shift and one circular right shift. Next to the word, the unit keeps a one-bit overflow flag. The flag is set when an arithmetic left shift fails to double the signed value.

A parallel-load strobe writes a new word from the data input. An execute strobe applies the selected shift to the stored word. The word width is a parameter that defaults to 8 bits. Reset is synchronous and active high.

Top module: `micro_shift_unit`

## Requirements
- R1: A cycle with `rst` high leaves `word_q` all zeros and `ovf_q` low after the next rising edge.
- R2: A cycle with `load_en` high copies `load_word` into `word_q` and clears `ovf_q`.
- R3: When `load_en` and `exec_en` are both high in one cycle, the load is performed and no shift happens.
- R4: Opcode 2'b00 (arithmetic right) shifts every bit one place toward bit 0 and keeps the most significant bit, so 10011100 becomes 11001110.
- R5: Opcode 2'b01 (logical left) shifts every bit one place toward the most significant end, drops the old top bit and inserts a zero at bit 0, so 11001110 becomes 10011100.
- R6: Opcode 2'b10 (circular right) shifts every bit one place toward bit 0 and moves the old bit 0 into the most significant bit, so 10011100 becomes 01001110.
- R7: Opcode 2'b11 (arithmetic left) gives the same word result as R5. It sets `ovf_q` to the XOR of the two most significant bits before the shift, so 01001110 becomes 10011100 with `ovf_q` high.
- R8: An executed opcode other than 2'b11 clears `ovf_q`.
- R9: A cycle with no strobe and no reset keeps both `word_q` and `ovf_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Parallel-load strobe |
| load_word | input | WIDTH | Word written on a load |
| exec_en | input | 1 | Execute the selected shift |
| opcode | input | 2 | Shift select: 00 arith right, 01 logical left, 10 circular right, 11 arith left |
| word_q | output | WIDTH | Register contents |
| ovf_q | output | 1 | Overflow flag of the last arithmetic left shift |

## Verification
The assertions assume that `rst` is high from time zero until at least one rising edge has passed. They also assume that the strobes and the opcode are at known values at every edge after that. The stimulus meets both assumptions. It starts in reset and changes all inputs only on falling edges, always to defined values. The sequences replay the worked chain of four shifts and then add wrap-around, sign-edge and simultaneous-strobe cases.

// File: rtl/shift_pkg.sv
package shift_pkg;
   typedef enum logic [1:0] {
      OP_ASR = 2'b00,
      OP_LSL = 2'b01,
      OP_ROR = 2'b10,
      OP_ASL = 2'b11
   } shift_op_e;
endpackage

// File: rtl/shift_datapath.sv
module shift_datapath
   import shift_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] cur,
   input  shift_op_e        op,
   output logic [WIDTH-1:0] nxt,
   output logic             ovf_nxt
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] right_arith;
   logic [WIDTH-1:0] right_circ;
   logic [WIDTH-1:0] left_fill;

   // Per-bit wiring of the three shift networks
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (b == MSB) begin : g_top
         assign right_arith[b] = cur[MSB];
         assign right_circ[b]  = cur[0];
      end else begin : g_mid
         assign right_arith[b] = cur[b+1];
         assign right_circ[b]  = cur[b+1];
      end
      if (b == 0) begin : g_low
         assign left_fill[b] = 1'b0;
      end else begin : g_up
         assign left_fill[b] = cur[b-1];
      end
   end

   always_comb begin
      unique case (op)
         OP_ASR:  nxt = right_arith;
         OP_LSL:  nxt = left_fill;
         OP_ROR:  nxt = right_circ;
         default: nxt = left_fill;
      endcase
      ovf_nxt = (op == OP_ASL) ? (cur[MSB] ^ cur[MSB-1]) : 1'b0;
   end
endmodule

// File: rtl/shift_state.sv
module shift_state #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_word,
   input  logic             exec_en,
   input  logic [WIDTH-1:0] shift_word,
   input  logic             shift_ovf,
   output logic [WIDTH-1:0] word_q,
   output logic             ovf_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         word_q <= '0;
         ovf_q  <= 1'b0;
      end else if (load_en) begin
         word_q <= load_word;
         ovf_q  <= 1'b0;
      end else if (exec_en) begin
         word_q <= shift_word;
         ovf_q  <= shift_ovf;
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (word_q == '0 && !ovf_q)); // R1
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (word_q == $past(load_word) && !ovf_q)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load_en && !exec_en) |=> ($stable(word_q) && $stable(ovf_q))); // R9
endmodule

// File: rtl/micro_shift_unit.sv
module micro_shift_unit
   import shift_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_word,
   input  logic             exec_en,
   input  logic [1:0]       opcode,
   output logic [WIDTH-1:0] word_q,
   output logic             ovf_q
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_check
      $error("micro_shift_unit: WIDTH must be at least 2");
   end

   shift_op_e        op;
   logic [WIDTH-1:0] shift_word;
   logic             shift_ovf;

   assign op = shift_op_e'(opcode);

   shift_datapath #(.WIDTH(WIDTH)) u_dp (
      .cur     (word_q),
      .op      (op),
      .nxt     (shift_word),
      .ovf_nxt (shift_ovf)
   );

   shift_state #(.WIDTH(WIDTH)) u_st (
      .clk        (clk),
      .rst        (rst),
      .load_en    (load_en),
      .load_word  (load_word),
      .exec_en    (exec_en),
      .shift_word (shift_word),
      .shift_ovf  (shift_ovf),
      .word_q     (word_q),
      .ovf_q      (ovf_q)
   );

   AST_ASR_SIGN: assert property (@(posedge clk) disable iff (rst)
      (exec_en && !load_en && opcode == 2'b00) |=>
      (word_q == {$past(word_q[MSB]), $past(word_q[MSB:1])})); // R4
   AST_LSL_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
      (exec_en && !load_en && opcode == 2'b01) |=>
      (word_q == {$past(word_q[MSB-1:0]), 1'b0})); // R5
   AST_ROR_WRAP: assert property (@(posedge clk) disable iff (rst)
      (exec_en && !load_en && opcode == 2'b10) |=>
      (word_q == {$past(word_q[0]), $past(word_q[MSB:1])})); // R6
   AST_ASL_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (exec_en && !load_en && opcode == 2'b11) |=>
      (ovf_q == ($past(word_q[MSB]) ^ $past(word_q[MSB-1])))); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (exec_en && !load_en && opcode != 2'b11) |=> !ovf_q); // R8
   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
      load_en |=> !ovf_q); // R2
endmodule

// File: tb/sim_micro_shift_unit.sv
module sim_micro_shift_unit;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load_en = 1'b0;
   logic [W-1:0] load_word = '0;
   logic         exec_en = 1'b0;
   logic [1:0]   opcode = 2'b00;
   logic [W-1:0] word_q;
   logic         ovf_q;

   typedef struct {
      logic [W-1:0] word;
      logic         ovf;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   logic [W-1:0] m_word = '0;
   logic         m_ovf = 1'b0;
   bit           done = 0;

   micro_shift_unit #(.WIDTH(W)) u0 (
      .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word),
      .exec_en(exec_en), .opcode(opcode), .word_q(word_q), .ovf_q(ovf_q)
   );

   always #10 clk = ~clk;

   // Drive one cycle, update the reference, queue the expected result
   task automatic step(input bit r, input bit ld, input logic [W-1:0] d,
                       input bit ex, input logic [1:0] op, input string tag);
      exp_t e;
      @(negedge clk);
      rst = r; load_en = ld; load_word = d; exec_en = ex; opcode = op;
      @(posedge clk);
      if (r) begin
         m_word = '0; m_ovf = 1'b0;
      end else if (ld) begin
         m_word = d; m_ovf = 1'b0;
      end else if (ex) begin
         case (op)
            2'b00: begin m_ovf = 1'b0; m_word = {m_word[W-1], m_word[W-1:1]}; end
            2'b01: begin m_ovf = 1'b0; m_word = {m_word[W-2:0], 1'b0}; end
            2'b10: begin m_ovf = 1'b0; m_word = {m_word[0], m_word[W-1:1]}; end
            default: begin m_ovf = m_word[W-1] ^ m_word[W-2]; m_word = {m_word[W-2:0], 1'b0}; end
         endcase
      end
      e.word = m_word; e.ovf = m_ovf; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compares away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (word_q !== e.word || ovf_q !== e.ovf) begin
            errors++;
            $display("FAIL %s: got word=%b ovf=%b, expected word=%b ovf=%b",
                     e.tag, word_q, ovf_q, e.word, e.ovf);
         end
      end
   end

   initial begin
      step(1, 0, '0, 0, 2'b00, "R1 reset state");
      step(0, 1, 8'b10011100, 0, 2'b00, "R2 load");
      step(0, 0, '0, 1, 2'b00, "R4 arith right keeps sign");
      step(0, 0, '0, 1, 2'b01, "R5 logical left");
      step(0, 0, '0, 1, 2'b10, "R6 circular right");
      step(0, 0, '0, 1, 2'b11, "R7 arith left overflow");
      step(0, 0, '0, 0, 2'b10, "R9 idle holds flag");
      step(0, 0, '0, 1, 2'b01, "R8 logical left clears flag");
      step(0, 1, 8'b00110011, 1, 2'b11, "R3 load beats execute");
      step(0, 0, '0, 1, 2'b11, "R7 arith left no overflow");
      step(0, 0, '0, 1, 2'b00, "R4 arith right positive");
      step(0, 1, 8'b00000001, 0, 2'b00, "R2 load low bit");
      step(0, 0, '0, 1, 2'b10, "R6 wrap bit0 to top");
      step(0, 0, '0, 1, 2'b11, "R7 arith left 10000000");
      step(0, 1, 8'b11000000, 0, 2'b00, "R2 load clears flag");
      step(0, 0, '0, 1, 2'b11, "R7 arith left 11000000");
      step(0, 0, '0, 1, 2'b11, "R7 arith left 10000000 again");
      step(0, 0, '0, 1, 2'b00, "R8 arith right clears flag");
      step(0, 1, 8'b01011010, 0, 2'b00, "R2 load pattern");
      step(0, 0, '0, 1, 2'b10, "R6 circular right pattern");
      step(1, 1, 8'hFF, 1, 2'b11, "R1 reset beats strobes");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule